// File: doc/BRIEF.md
# Cache Line Coherency State Controller

This block keeps a two-bit coherency state for every line of a small direct-mapped cache and moves that state as the processor reads and writes, as lines are filled from memory, and as the bus snoops the cache. The write policy is picked per line when the line is allocated: a write-back allocation gives a clean exclusive line that later becomes modified, and a write-through allocation gives a line whose every write goes to memory as well. The data array and tag compare live elsewhere; the block is told through `cpu_hit` whether the tag matched.

The processor holds a request with its index, direction, hit flag and allocation attribute until `cpu_done` pulses. Line fills and write-through cycles are handed to the bus through request/acknowledge pairs addressed by `bus_idx`. Modified data that must be copied to memory (because of a snoop or an eviction) is queued per line; the queue raises `wb_req` for the lowest pending index and keeps that line marked in `line_busy` until `wb_ack`. Processor accesses to a marked line wait.

Top module: `mei_line_ctrl`

## Requirements
- R1: After a synchronous active-low reset every line is invalid, `line_busy` is zero and no bus request is raised; `cpu_state` shows the stored state of line `cpu_idx` coded 0 = invalid, 1 = write-through (S), 2 = clean write-back (E), 3 = modified (M).
- R2: A read that misses (line invalid, or `cpu_hit` low on an S or E line) raises `fill_req` with `bus_idx` equal to the index; in the cycle `fill_ack` is high `cpu_done` pulses and the line becomes E when `cpu_wb_attr` was 1, S when it was 0.
- R3: A read hit on an M, E or S line, and a write hit on an M line, pulse `cpu_done` in the cycle the request is presented, raise no bus request and leave the state unchanged.
- R4: A write hit on an E line completes in the request cycle with no bus request and moves the line to M; a line never reaches M from any state other than E.
- R5: A write hit on an S line raises `wt_req`, holds it until `wt_ack`, completes with the acknowledge, and the line stays S.
- R6: A write miss (line invalid, or `cpu_hit` low) raises `wt_req` and does not allocate: the line's state is unchanged.
- R7: A snoop with `snoop_inv` high makes the line invalid; if the line was M, its write-back is queued and its `line_busy` bit is set in the next cycle.
- R8: A snoop with `snoop_inv` low on an M line queues a write-back and leaves the line E; on an I, S or E line it changes nothing.
- R9: `wb_req` stays high while any write-back is queued, `wb_idx` names the lowest queued index, and `wb_ack` removes exactly that entry.
- R10: A processor access to a line whose `line_busy` bit is set gets no `cpu_done` and raises no fill or write-through until the write-back of that line is acknowledged.
- R11: A snoop and a processor access to the same index in the same cycle act snoop first; the access is decided on the state the snoop leaves.
- R12: A read with `cpu_hit` low on an M line first queues the line's write-back and invalidates it, then fills it after `wb_ack`, ending in E or S by `cpu_wb_attr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_idx | input | IDX_W | Line index of the access |
| cpu_hit | input | 1 | Tag matched |
| cpu_wb_attr | input | 1 | Allocation attribute: 1 = write-back, 0 = write-through |
| cpu_done | output | 1 | Access completes this cycle |
| cpu_state | output | 2 | Stored state of line `cpu_idx` |
| line_busy | output | NUM_LINES | Lines with a queued write-back |
| snoop_valid | input | 1 | Snoop strobe |
| snoop_idx | input | IDX_W | Snooped line index |
| snoop_inv | input | 1 | Snoop invalidates the line |
| fill_req | output | 1 | Line fill request |
| fill_ack | input | 1 | Line fill complete |
| wt_req | output | 1 | Write-through cycle request |
| wt_ack | input | 1 | Write-through complete |
| bus_idx | output | IDX_W | Index for fill and write-through |
| wb_req | output | 1 | Write-back request |
| wb_ack | input | 1 | Write-back complete |
| wb_idx | output | IDX_W | Index being written back |

## Verification
Every cycle the assertions check that a line enters M only from E, that fill, write-through and write-back requests hold until acknowledged, that an invalidating snoop on a modified line marks it busy next cycle, and that an access never completes from idle on a busy line. The state a line reaches after each kind of access or snoop, the lowest-first order of write-backs, the eviction-then-fill sequence and the snoop-first resolution of same-cycle collisions are shown only by the bench's directed and random scenarios against its own state model.

// File: rtl/mei_pkg.sv
// Shared types for the line coherency controller.
// Assumes: a two-bit code per line; the code values are visible on cpu_state.
package mei_pkg;
    typedef enum logic [1:0] {
        LS_I = 2'd0,   // invalid
        LS_S = 2'd1,   // valid, write-through allocation
        LS_E = 2'd2,   // valid, write-back allocation, clean
        LS_M = 2'd3    // modified
    } line_st_t;
endpackage

// File: rtl/mei_state_array.sv
// Per-line state registers with a snoop write port and a processor write port.
// Assumes: when both ports write one line in a cycle, the processor value was
// computed from the post-snoop state, so it wins.
module mei_state_array
    import mei_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snp_we,
    input  logic [IDX_W-1:0] snp_idx,
    input  line_st_t         snp_st,
    input  logic             cpu_we,
    input  logic [IDX_W-1:0] cpu_widx,
    input  line_st_t         cpu_wst,
    output line_st_t         st_q [NUM_LINES]
);
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        // Hold one line's state; processor update overrides snoop update.
        always_ff @(posedge clk) begin
            if (!rst_n)
                st_q[g] <= LS_I;
            else if (cpu_we && cpu_widx == IDX_W'(g))
                st_q[g] <= cpu_wst;
            else if (snp_we && snp_idx == IDX_W'(g))
                st_q[g] <= snp_st;
        end

        // R4
        enter_m_from_e_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q[g] == LS_M && $past(st_q[g]) != LS_M) |-> $past(st_q[g]) == LS_E);
    end
endmodule

// File: rtl/mei_snoop_unit.sv
// Decides the state change and write-back need of one snoop.
// Assumes: cur_st is the stored state of snoop_idx; purely combinational.
module mei_snoop_unit
    import mei_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic                 snoop_valid,
    input  logic                 snoop_inv,
    input  logic [IDX_W-1:0]     snoop_idx,
    input  line_st_t             cur_st,
    output logic                 st_we,
    output line_st_t             st_new,
    output logic [NUM_LINES-1:0] wb_set
);
    logic need_wb;

    // Map current state and invalidate flag to the new state.
    always_comb begin
        st_we   = 1'b0;
        st_new  = cur_st;
        need_wb = 1'b0;
        if (snoop_valid) begin
            need_wb = (cur_st == LS_M);
            if (snoop_inv) begin
                st_we  = (cur_st != LS_I);
                st_new = LS_I;
            end else if (cur_st == LS_M) begin
                st_we  = 1'b1;
                st_new = LS_E;
            end
        end
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_dec
        assign wb_set[g] = need_wb && (snoop_idx == IDX_W'(g));
    end
endmodule

// File: rtl/mei_wb_tracker.sv
// Queue of lines awaiting write-back, served lowest index first.
// Assumes: a line is never queued twice; set wins over clear in one cycle.
module mei_wb_tracker #(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] set_vec,
    input  logic                 wb_ack,
    output logic [NUM_LINES-1:0] pend_q,
    output logic                 wb_req,
    output logic [IDX_W-1:0]     wb_idx
);
    logic [NUM_LINES-1:0] clr_vec;

    // Pick the lowest pending index.
    always_comb begin
        wb_idx = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--)
            if (pend_q[i]) wb_idx = IDX_W'(i);
    end

    assign wb_req = |pend_q;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_clr
        assign clr_vec[g] = wb_ack && wb_req && (wb_idx == IDX_W'(g));
    end

    // Update the pending set.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_vec) | set_vec;
    end

    // R9
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> wb_req);
endmodule

// File: rtl/mei_access_fsm.sv
// Processor access sequencer: hits, fills, write-throughs, evictions.
// Assumes: cpu_* inputs are held until cpu_done; post_st already reflects a
// same-cycle snoop; line_blocked includes write-backs queued this cycle.
module mei_access_fsm
    import mei_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req,
    input  logic             cpu_we,
    input  logic [IDX_W-1:0] cpu_idx,
    input  logic             cpu_hit,
    input  logic             cpu_wb_attr,
    input  line_st_t         post_st,
    input  logic             line_blocked,
    input  logic             fill_ack,
    input  logic             wt_ack,
    output logic             cpu_done,
    output logic             fill_req,
    output logic             wt_req,
    output logic [IDX_W-1:0] bus_idx,
    output logic             st_we,
    output logic [IDX_W-1:0] st_widx,
    output line_st_t         st_wst,
    output logic             evict
);
    typedef enum logic [1:0] {AF_IDLE, AF_FILL, AF_WT} af_t;

    af_t              cur_q, nxt;
    logic [IDX_W-1:0] idx_q;
    logic             attr_q;
    logic             hit_eff;

    assign hit_eff = cpu_hit && (post_st != LS_I);

    // Decide the next step and any state write for the current cycle.
    always_comb begin
        nxt      = cur_q;
        cpu_done = 1'b0;
        st_we    = 1'b0;
        st_widx  = cpu_idx;
        st_wst   = post_st;
        evict    = 1'b0;
        unique case (cur_q)
            AF_IDLE: begin
                if (cpu_req && !line_blocked) begin
                    if (!cpu_we) begin
                        if (hit_eff) begin
                            cpu_done = 1'b1;
                        end else if (post_st == LS_M) begin
                            evict  = 1'b1;
                            st_we  = 1'b1;
                            st_wst = LS_I;
                        end else begin
                            nxt = AF_FILL;
                        end
                    end else if (hit_eff && post_st == LS_E) begin
                        st_we    = 1'b1;
                        st_wst   = LS_M;
                        cpu_done = 1'b1;
                    end else if (hit_eff && post_st == LS_M) begin
                        cpu_done = 1'b1;
                    end else begin
                        nxt = AF_WT;
                    end
                end
            end
            AF_FILL: begin
                if (fill_ack) begin
                    st_we    = 1'b1;
                    st_widx  = idx_q;
                    st_wst   = attr_q ? LS_E : LS_S;
                    cpu_done = 1'b1;
                    nxt      = AF_IDLE;
                end
            end
            AF_WT: begin
                if (wt_ack) begin
                    cpu_done = 1'b1;
                    nxt      = AF_IDLE;
                end
            end
            default: nxt = AF_IDLE;
        endcase
    end

    // Advance the sequencer and latch the access that starts a bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= AF_IDLE;
            idx_q  <= '0;
            attr_q <= 1'b0;
        end else begin
            cur_q <= nxt;
            if (cur_q == AF_IDLE && nxt != AF_IDLE) begin
                idx_q  <= cpu_idx;
                attr_q <= cpu_wb_attr;
            end
        end
    end

    assign fill_req = (cur_q == AF_FILL);
    assign wt_req   = (cur_q == AF_WT);
    assign bus_idx  = idx_q;

    // R2
    fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_ack) |=> (fill_req && $stable(bus_idx)));

    // R5
    wt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wt_req && !wt_ack) |=> (wt_req && $stable(bus_idx)));
endmodule

// File: rtl/mei_line_ctrl.sv
// Top: coherency state controller for a direct-mapped line array.
// Assumes: processor inputs held stable until cpu_done; one snoop per cycle;
// the snoop is applied first and the processor sees the resulting state.
module mei_line_ctrl
    import mei_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_req,
    input  logic                 cpu_we,
    input  logic [IDX_W-1:0]     cpu_idx,
    input  logic                 cpu_hit,
    input  logic                 cpu_wb_attr,
    output logic                 cpu_done,
    output logic [1:0]           cpu_state,
    output logic [NUM_LINES-1:0] line_busy,
    input  logic                 snoop_valid,
    input  logic [IDX_W-1:0]     snoop_idx,
    input  logic                 snoop_inv,
    output logic                 fill_req,
    input  logic                 fill_ack,
    output logic                 wt_req,
    input  logic                 wt_ack,
    output logic [IDX_W-1:0]     bus_idx,
    output logic                 wb_req,
    input  logic                 wb_ack,
    output logic [IDX_W-1:0]     wb_idx
);
    line_st_t             st_q [NUM_LINES];
    logic                 snp_we;
    line_st_t             snp_st;
    logic [NUM_LINES-1:0] snp_set;
    logic                 cpu_st_we;
    logic [IDX_W-1:0]     cpu_widx;
    line_st_t             cpu_wst;
    logic                 evict;
    logic [NUM_LINES-1:0] evict_set;
    logic [NUM_LINES-1:0] busy_eff;
    line_st_t             post_st;

    mei_snoop_unit #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_snoop (
        .snoop_valid (snoop_valid),
        .snoop_inv   (snoop_inv),
        .snoop_idx   (snoop_idx),
        .cur_st      (st_q[snoop_idx]),
        .st_we       (snp_we),
        .st_new      (snp_st),
        .wb_set      (snp_set)
    );

    // Processor sees the state as left by a same-cycle snoop.
    always_comb begin
        post_st = st_q[cpu_idx];
        if (snp_we && snoop_idx == cpu_idx) post_st = snp_st;
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_ev
        assign evict_set[g] = evict && (cpu_idx == IDX_W'(g));
    end

    assign busy_eff = line_busy | snp_set;

    mei_access_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .cpu_idx      (cpu_idx),
        .cpu_hit      (cpu_hit),
        .cpu_wb_attr  (cpu_wb_attr),
        .post_st      (post_st),
        .line_blocked (busy_eff[cpu_idx]),
        .fill_ack     (fill_ack),
        .wt_ack       (wt_ack),
        .cpu_done     (cpu_done),
        .fill_req     (fill_req),
        .wt_req       (wt_req),
        .bus_idx      (bus_idx),
        .st_we        (cpu_st_we),
        .st_widx      (cpu_widx),
        .st_wst       (cpu_wst),
        .evict        (evict)
    );

    mei_state_array #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .snp_we   (snp_we),
        .snp_idx  (snoop_idx),
        .snp_st   (snp_st),
        .cpu_we   (cpu_st_we),
        .cpu_widx (cpu_widx),
        .cpu_wst  (cpu_wst),
        .st_q     (st_q)
    );

    mei_wb_tracker #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_wb (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (snp_set | evict_set),
        .wb_ack  (wb_ack),
        .pend_q  (line_busy),
        .wb_req  (wb_req),
        .wb_idx  (wb_idx)
    );

    assign cpu_state = st_q[cpu_idx];

    // R7
    inv_modified_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_valid && snoop_inv && st_q[snoop_idx] == LS_M)
            |=> line_busy[$past(snoop_idx)]);

    // R10
    no_done_on_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && !fill_req && !wt_req) |-> !line_busy[cpu_idx]);
endmodule

// File: tb/mei_line_ctrl_test.sv
`timescale 1ns/100ps
module mei_line_ctrl_test;
    localparam int NL = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 0, cpu_we = 0, cpu_hit = 0, cpu_wb_attr = 0;
    logic [IW-1:0] cpu_idx = '0;
    logic          cpu_done;
    logic [1:0]    cpu_state;
    logic [NL-1:0] line_busy;
    logic          snoop_valid = 0, snoop_inv = 0;
    logic [IW-1:0] snoop_idx = '0;
    logic          fill_req, wt_req, wb_req;
    logic          fill_ack = 0, wt_ack = 0, wb_ack = 0;
    logic [IW-1:0] bus_idx, wb_idx;

    int checks = 0;
    int fails  = 0;
    int ref_st [NL];
    bit ref_pend [NL];

    always #2 clk = ~clk;

    mei_line_ctrl #(.NUM_LINES(NL), .IDX_W(IW)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_idx(cpu_idx), .cpu_hit(cpu_hit), .cpu_wb_attr(cpu_wb_attr),
        .cpu_done(cpu_done), .cpu_state(cpu_state), .line_busy(line_busy),
        .snoop_valid(snoop_valid), .snoop_idx(snoop_idx), .snoop_inv(snoop_inv),
        .fill_req(fill_req), .fill_ack(fill_ack), .wt_req(wt_req), .wt_ack(wt_ack),
        .bus_idx(bus_idx), .wb_req(wb_req), .wb_ack(wb_ack), .wb_idx(wb_idx)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic int lowest_pend();
        for (int i = 0; i < NL; i++) if (ref_pend[i]) return i;
        return -1;
    endfunction

    function automatic int pend_vec();
        int v = 0;
        for (int i = 0; i < NL; i++) if (ref_pend[i]) v |= (1 << i);
        return v;
    endfunction

    // Snoop one line and compare the resulting state and busy set.
    task automatic do_snoop(input int idx, input bit inv, input string tag);
        @(negedge clk);
        snoop_valid = 1; snoop_idx = IW'(idx); snoop_inv = inv;
        if (ref_st[idx] == 3) ref_pend[idx] = 1;
        if (inv) ref_st[idx] = 0;
        else if (ref_st[idx] == 3) ref_st[idx] = 2;
        @(negedge clk);
        snoop_valid = 0;
        cpu_idx = IW'(idx);
        #0.5;
        chk(cpu_state == 2'(ref_st[idx]), {tag, " state"}, cpu_state, ref_st[idx]);
        chk(int'(line_busy) == pend_vec(), {tag, " busy"}, line_busy, pend_vec());
    endtask

    // Acknowledge up to n queued write-backs, checking lowest-first order.
    task automatic drain_wb(input int n);
        @(negedge clk);
        #0.5;
        for (int k = 0; k < n && wb_req; k++) begin
            chk(int'(wb_idx) == lowest_pend(), "R9 write-back order", wb_idx, lowest_pend());
            if (lowest_pend() >= 0) ref_pend[lowest_pend()] = 0;
            wb_ack = 1;
            @(negedge clk);
            wb_ack = 0;
            #0.5;
        end
        chk(int'(line_busy) == pend_vec(), "R9 busy after acks", line_busy, pend_vec());
        chk(wb_req == (pend_vec() != 0), "R9 wb_req level", wb_req, pend_vec() != 0);
    endtask

    // One processor access, optionally with a same-cycle snoop on the same line.
    task automatic cpu_access(input bit we, input int idx, input bit hit, input bit attr,
                              input bit snp, input bit sinv, input string tag);
        int st;
        bit hit_eff, exp_fill, exp_wt, add_pend, busy0, zero_delay, fin;
        bit saw_fill, saw_wt;
        int dcyc, c;
        exp_fill = 0; exp_wt = 0; add_pend = 0; fin = 0;
        saw_fill = 0; saw_wt = 0; dcyc = -1;
        if (snp) begin
            if (ref_st[idx] == 3) add_pend = 1;
            if (sinv) ref_st[idx] = 0;
            else if (ref_st[idx] == 3) ref_st[idx] = 2;
        end
        busy0 = ref_pend[idx] || add_pend;
        st = ref_st[idx];
        hit_eff = hit && st != 0;
        if (!we) begin
            if (!hit_eff) begin
                exp_fill = 1;
                if (st == 3) begin add_pend = 1; ref_st[idx] = 0; busy0 = 1; end
            end
        end else if (hit_eff) begin
            if (st == 2) ref_st[idx] = 3;
            else if (st == 1) exp_wt = 1;
        end else begin
            exp_wt = 1;
        end
        zero_delay = !busy0 && !exp_fill && !exp_wt;

        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_idx = IW'(idx); cpu_hit = hit; cpu_wb_attr = attr;
        if (snp) begin snoop_valid = 1; snoop_idx = IW'(idx); snoop_inv = sinv; end
        c = 0;
        while (!fin && c < 40) begin
            #0.5;
            if (c == 1 && add_pend) ref_pend[idx] = 1;
            if (fill_req) begin
                saw_fill = 1;
                chk(int'(bus_idx) == idx, {tag, " fill index"}, bus_idx, idx);
                chk(!ref_pend[idx], "R10 fill before write-back", 1, 0);
                fill_ack = 1;
            end
            if (wt_req) begin
                saw_wt = 1;
                chk(int'(bus_idx) == idx, {tag, " write-through index"}, bus_idx, idx);
                chk(!ref_pend[idx], "R10 write-through before write-back", 1, 0);
                wt_ack = 1;
            end
            if (wb_req) begin
                chk(int'(wb_idx) == lowest_pend(), "R9 write-back order", wb_idx, lowest_pend());
                if (lowest_pend() >= 0) ref_pend[lowest_pend()] = 0;
                wb_ack = 1;
            end
            #0.5;
            if (cpu_done) begin fin = 1; dcyc = c; end
            @(negedge clk);
            fill_ack = 0; wt_ack = 0; wb_ack = 0;
            if (c == 0) snoop_valid = 0;
            c++;
        end
        cpu_req = 0; snoop_valid = 0;
        if (exp_fill) ref_st[idx] = attr ? 2 : 1;
        #0.5;
        chk(fin, {tag, " completed"}, fin, 1);
        chk(cpu_state == 2'(ref_st[idx]), {tag, " state"}, cpu_state, ref_st[idx]);
        chk(saw_fill == exp_fill, {tag, " fill request"}, saw_fill, exp_fill);
        chk(saw_wt == exp_wt, {tag, " write-through request"}, saw_wt, exp_wt);
        chk(int'(line_busy) == pend_vec(), {tag, " busy"}, line_busy, pend_vec());
        if (zero_delay) chk(dcyc == 0, {tag, " same-cycle done"}, dcyc, 0);
        if (busy0) chk(dcyc > 0, "R10 stalled on busy line", dcyc, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20231));
        for (int i = 0; i < NL; i++) begin ref_st[i] = 0; ref_pend[i] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        for (int i = 0; i < NL; i++) begin
            cpu_idx = IW'(i);
            #0.5;
            chk(cpu_state == 2'd0, "R1 reset state", cpu_state, 0);
            @(negedge clk);
        end
        chk(!fill_req && !wt_req && !wb_req, "R1 no bus request", fill_req | wt_req | wb_req, 0);
        chk(line_busy == '0, "R1 busy clear", line_busy, 0);

        cpu_access(0, 1, 0, 1, 0, 0, "R2 read miss write-back attr");
        cpu_access(0, 3, 1, 0, 0, 0, "R2 read miss write-through attr");
        cpu_access(0, 1, 1, 0, 0, 0, "R3 read hit E");
        cpu_access(0, 3, 1, 1, 0, 0, "R3 read hit S");
        cpu_access(1, 1, 1, 0, 0, 0, "R4 write hit E");
        cpu_access(1, 1, 1, 0, 0, 0, "R3 write hit M");
        cpu_access(0, 1, 1, 0, 0, 0, "R3 read hit M");
        cpu_access(1, 3, 1, 0, 0, 0, "R5 write hit S");
        cpu_access(1, 5, 1, 1, 0, 0, "R6 write to invalid");
        cpu_access(1, 1, 0, 1, 0, 0, "R6 write tag miss on M");

        do_snoop(1, 0, "R8 non-invalidating snoop on M");
        do_snoop(3, 0, "R8 non-invalidating snoop on S");
        do_snoop(5, 0, "R8 non-invalidating snoop on I");
        drain_wb(4);
        do_snoop(1, 0, "R8 non-invalidating snoop on E");
        cpu_access(1, 1, 1, 0, 0, 0, "R4 write hit E again");
        do_snoop(1, 1, "R7 invalidating snoop on M");
        do_snoop(3, 1, "R7 invalidating snoop on S");
        drain_wb(4);

        // R9 and R10: two queued lines, access to the higher one waits for both
        cpu_access(0, 6, 0, 1, 0, 0, "R2 fill line 6");
        cpu_access(1, 6, 1, 0, 0, 0, "R4 line 6 to M");
        cpu_access(0, 2, 0, 1, 0, 0, "R2 fill line 2");
        cpu_access(1, 2, 1, 0, 0, 0, "R4 line 2 to M");
        do_snoop(6, 0, "R8 queue line 6");
        do_snoop(2, 0, "R8 queue line 2");
        cpu_access(0, 6, 1, 0, 0, 0, "R10 read of busy line");

        // R12 eviction of a modified line on a tag miss
        cpu_access(0, 4, 0, 1, 0, 0, "R2 fill line 4");
        cpu_access(1, 4, 1, 0, 0, 0, "R4 line 4 to M");
        cpu_access(0, 4, 0, 0, 0, 0, "R12 evict then fill");

        // R11 same-cycle snoop and access
        cpu_access(0, 7, 0, 1, 0, 0, "R2 fill line 7");
        cpu_access(1, 7, 1, 0, 1, 1, "R11 invalidate with write");
        cpu_access(0, 0, 0, 1, 0, 0, "R2 fill line 0");
        cpu_access(1, 0, 1, 0, 0, 0, "R4 line 0 to M");
        cpu_access(1, 0, 1, 0, 1, 0, "R11 non-invalidating snoop with write");
        cpu_access(0, 0, 1, 0, 1, 1, "R11 invalidate with read");
        drain_wb(8);

        // Random mix checked against the model
        for (int n = 0; n < 400; n++) begin
            int r = $urandom % 10;
            if (r < 3)
                do_snoop($urandom % NL, $urandom % 2, "R7 R8 random snoop");
            else if (r < 4)
                drain_wb(1);
            else
                cpu_access($urandom % 2, $urandom % NL, ($urandom % 4) != 0, $urandom % 2,
                           ($urandom % 8) == 0, $urandom % 2, "R11 random access");
        end
        drain_wb(8);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule